// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between a processor core and an external memory bus. On that bus, a single 8-bit port carries the low byte of the address first and then the data byte. The core makes one request at a time. Each request carries a 16-bit address, an access kind (code fetch, data read or data write) and a write byte. The controller turns each request into a fixed pin sequence. The sequence is an address phase, a latch-release phase, a strobe phase and a recovery phase. Each phase lasts `PHASE_CLKS` clocks.

During the address phase the low address byte is driven on the shared port and the address-latch strobe is high. An external transparent latch captures the byte on that strobe, and the high byte sits on its own port for the whole access. Code fetches use the active-low program strobe. Data loads use the active-low read strobe and data stores use the active-low write strobe. The shared port is modelled as separate out, enable and in signals that meet at the pad.

An active-low force-external input decides where code fetches go. When it is low, every code fetch goes to the bus. When it is high, fetches below `INT_CODE_LIMIT` belong to on-chip code space. Such a fetch leaves the pins quiet and completes at once with 0xFF.

Top module: `xbus_ctrl`

States:
- `S_IDLE` (ready)
- `S_ADDR` (latch strobe high, low address driven)
- `S_HOLD` (latch strobe low; the port carries write data or is released)
- `S_STROBE` (one memory strobe active)
- `S_RECOV` (all strobes inactive, port released)
- `S_LOCAL` (on-chip fetch, one cycle)

Transitions:
- `S_IDLE` to `S_ADDR` on an accepted bus request.
- `S_IDLE` to `S_LOCAL` on an accepted on-chip fetch.
- `S_ADDR` to `S_HOLD`, `S_HOLD` to `S_STROBE`, `S_STROBE` to `S_RECOV` and `S_RECOV` to `S_IDLE`, each after `PHASE_CLKS` cycles.
- `S_LOCAL` to `S_IDLE` after one cycle.

## Requirements
- R1: After reset the block is ready, `ale` is low, `psen_n`, `rd_n` and `wr_n` are high, `ad_oe` is low and `done` is low.
- R2: During the first `PHASE_CLKS` cycles of a bus access, `ale` is high and `ad_out` drives the address bits [7:0] with `ad_oe` high. `hi_addr` shows address bits [15:8] for the whole access.
- R3: A code fetch (`req_kind` = 2'b00) holds `psen_n` low for exactly the third phase, and `rd_n` and `wr_n` stay high.
- R4: A data read (`req_kind` = 2'b01) holds `rd_n` low for exactly the third phase with `psen_n` high. `ad_oe` is low from the second phase on, so the port is released before the strobe.
- R5: A data write (`req_kind` = 2'b10 or 2'b11) drives the write byte on `ad_out` with `ad_oe` high through the second and third phases. `wr_n` is low for exactly the third phase.
- R6: For fetches and reads, `rdata` carries the byte present on `ad_in` at the clock edge that ends the strobe phase, and it is valid while `done` is high.
- R7: At most one of `psen_n`, `rd_n` and `wr_n` is low in any cycle, and `ale` is low whenever any of them is low.
- R8: A bus access lasts 4×`PHASE_CLKS` cycles from acceptance. `done` is high for one cycle, the last one. `ready` is low throughout, and a request raised while busy is ignored.
- R9: A code fetch with `ext_only_n` high and address below `INT_CODE_LIMIT` produces no pin activity. It completes with `done` in the next cycle and `rdata` = 8'hFF. Otherwise the fetch uses the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request from the core, taken when ready |
| req_kind | input | 2 | 00 fetch, 01 read, 1x write |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Byte to store |
| ext_only_n | input | 1 | Low forces all code fetches onto the bus |
| ready | output | 1 | Idle, can accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Returned byte |
| hi_addr | output | 8 | High address port |
| ad_out | output | 8 | Shared port, outgoing value |
| ad_oe | output | 1 | Shared port drive enable |
| ad_in | input | 8 | Shared port, incoming value |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program memory strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
Writes with the byte patterns 0x00, 0xFF and 0xA5 go to scattered addresses and to the address extremes 0x0000 and 0xFFFF. Reading them back through the bench's latch-and-memory model shows whether the low address byte was latched and the high byte held correctly. Fetches are issued with the force-external input low and high, and on both sides of the on-chip limit. This separates bus fetches from on-chip completions. Requests raised while busy, and back-to-back requests, show that acceptance happens only when idle. A read of a location never written shows that the port was released and the sampled value is returned.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [1:0] {
        K_FETCH = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2,
        K_WRALT = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_HOLD,
        S_STROBE,
        S_RECOV,
        S_LOCAL
    } state_e;

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int PHASE_CLKS = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   local_hit,
    output state_e state,
    output logic   last
);
    localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;

    logic [CW-1:0] cnt;
    state_e        nxt;

    assign last = (cnt == CW'(PHASE_CLKS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (nxt != state) ? '0 : cnt + CW'(1);
        end
    end

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = local_hit ? S_LOCAL : S_ADDR;
            S_ADDR:   if (last) nxt = S_HOLD;
            S_HOLD:   if (last) nxt = S_STROBE;
            S_STROBE: if (last) nxt = S_RECOV;
            S_RECOV:  if (last) nxt = S_IDLE;
            S_LOCAL:  nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

endmodule

// File: rtl/xbus_capture.sv
module xbus_capture
    import xbus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept,
    input  logic        local_hit,
    input  kind_e       kind,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    input  logic        sample,
    input  logic [7:0]  ad_in,
    output kind_e       kind_q,
    output logic [15:0] addr_q,
    output logic [7:0]  wdata_q,
    output logic [7:0]  rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= K_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            if (accept) begin
                kind_q  <= kind;
                addr_q  <= addr;
                wdata_q <= wdata;
                if (local_hit) rdata <= 8'hFF;
            end
            if (sample) rdata <= ad_in;
        end
    end

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
    import xbus_pkg::*;
(
    input  state_e      state,
    input  logic        last,
    input  kind_e       kind_q,
    input  logic [15:0] addr_q,
    input  logic [7:0]  wdata_q,
    output logic        ready,
    output logic        done,
    output logic [7:0]  hi_addr,
    output logic [7:0]  ad_out,
    output logic        ad_oe,
    output logic        ale,
    output logic        psen_n,
    output logic        rd_n,
    output logic        wr_n
);
    logic is_wr;
    logic is_fetch;

    assign is_wr    = kind_q[1];
    assign is_fetch = (kind_q == K_FETCH);

    // output decode
    always_comb begin
        ready   = 1'b0;
        done    = 1'b0;
        hi_addr = addr_q[15:8];
        ad_out  = addr_q[7:0];
        ad_oe   = 1'b0;
        ale     = 1'b0;
        psen_n  = 1'b1;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        unique case (state)
            S_IDLE: ready = 1'b1;
            S_ADDR: begin
                ale   = 1'b1;
                ad_oe = 1'b1;
            end
            S_HOLD: begin
                if (is_wr) begin
                    ad_oe  = 1'b1;
                    ad_out = wdata_q;
                end
            end
            S_STROBE: begin
                if (is_wr) begin
                    ad_oe  = 1'b1;
                    ad_out = wdata_q;
                    wr_n   = 1'b0;
                end else if (is_fetch) begin
                    psen_n = 1'b0;
                end else begin
                    rd_n = 1'b0;
                end
            end
            S_RECOV: done = last;
            S_LOCAL: done = 1'b1;
            default: ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int PHASE_CLKS     = 2,
    parameter int INT_CODE_LIMIT = 'h1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [1:0]  req_kind,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_wdata,
    input  logic        ext_only_n,
    output logic        ready,
    output logic        done,
    output logic [7:0]  rdata,
    output logic [7:0]  hi_addr,
    output logic [7:0]  ad_out,
    output logic        ad_oe,
    input  logic [7:0]  ad_in,
    output logic        ale,
    output logic        psen_n,
    output logic        rd_n,
    output logic        wr_n
);
    localparam logic [16:0] LIMIT = 17'(INT_CODE_LIMIT);

    state_e      state;
    logic        last;
    logic        start;
    logic        local_hit;
    logic        sample;
    kind_e       kind_in;
    kind_e       kind_q;
    logic [15:0] addr_q;
    logic [7:0]  wdata_q;

    assign kind_in   = kind_e'(req_kind);
    assign start     = req_valid && (state == S_IDLE);
    assign local_hit = ext_only_n && (kind_in == K_FETCH) && ({1'b0, req_addr} < LIMIT);
    assign sample    = (state == S_STROBE) && last && !kind_q[1];

    xbus_seq #(.PHASE_CLKS(PHASE_CLKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .local_hit (local_hit),
        .state     (state),
        .last      (last)
    );

    xbus_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (start),
        .local_hit (local_hit),
        .kind      (kind_in),
        .addr      (req_addr),
        .wdata     (req_wdata),
        .sample    (sample),
        .ad_in     (ad_in),
        .kind_q    (kind_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rdata     (rdata)
    );

    xbus_pins u_pins (
        .state   (state),
        .last    (last),
        .kind_q  (kind_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .ready   (ready),
        .done    (done),
        .hi_addr (hi_addr),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .ale     (ale),
        .psen_n  (psen_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n)
    );

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ready,
    input logic       done,
    input logic [7:0] hi_addr,
    input logic       ad_oe,
    input logic       ale,
    input logic       psen_n,
    input logic       rd_n,
    input logic       wr_n
);
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

    p_ale_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n || !wr_n) |-> !ale);

    p_release_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(psen_n)) |-> (!ad_oe && !$past(ad_oe)));

    p_write_driven_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    p_ale_driven_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ad_oe);

    p_hi_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> $stable(hi_addr));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ready);

endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ready   (ready),
    .done    (done),
    .hi_addr (hi_addr),
    .ad_oe   (ad_oe),
    .ale     (ale),
    .psen_n  (psen_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n)
);

// File: tb/xbus_ctrl_bench.sv
module xbus_ctrl_bench;
    localparam int PH  = 3;
    localparam int LIM = 'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ext_only_n = 1'b0;
    logic        ready, done, ad_oe, ale, psen_n, rd_n, wr_n;
    logic [7:0]  rdata, hi_addr, ad_out, ad_in;

    int total = 0;
    int bad   = 0;
    bit run_chk = 1'b0;

    always #2 clk = ~clk;

    xbus_ctrl #(.PHASE_CLKS(PH), .INT_CODE_LIMIT(LIM)) u_xbus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .ext_only_n(ext_only_n),
        .ready(ready), .done(done), .rdata(rdata), .hi_addr(hi_addr),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale),
        .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    // external pad-side world: address latch plus two memories
    function automatic logic [7:0] code_byte(logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    logic [7:0] lat_q = 8'h00;
    logic [7:0] ext_data [int];

    function automatic logic [7:0] ext_rd(logic [15:0] a);
        if (ext_data.exists(int'(a))) return ext_data[int'(a)];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (ale && ad_oe) lat_q <= ad_out;
        if (!wr_n && ad_oe) ext_data[int'({hi_addr, lat_q})] = ad_out;
    end

    assign ad_in = !psen_n ? code_byte({hi_addr, lat_q}) :
                   !rd_n   ? ext_rd({hi_addr, lat_q}) : 8'hEE;

    // behavioural reference model
    int         m_k = 0;
    int         m_total = 1;
    int         m_kind = 0;
    bit         m_local = 1'b0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_wdata = '0;
    logic [7:0]  m_rd = '0;
    logic [7:0]  ref_mem [int];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_k = 0;
        end else if (m_k == 0) begin
            if (req_valid) begin
                m_kind  = int'(req_kind);
                m_addr  = req_addr;
                m_wdata = req_wdata;
                m_local = ext_only_n && m_kind == 0 && int'(req_addr) < LIM;
                m_total = m_local ? 1 : 4 * PH;
                if (m_local) m_rd = 8'hFF;
                else if (m_kind == 0) m_rd = code_byte(req_addr);
                else if (m_kind == 1) m_rd = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : 8'h00;
                else ref_mem[int'(req_addr)] = req_wdata;
                m_k = 1;
            end
        end else if (m_k == m_total) begin
            m_k = 0;
        end else begin
            m_k = m_k + 1;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (run_chk) begin
            int  ph;
            bit  bus;
            ph  = (m_k > 0) ? (m_k - 1) / PH : -1;
            bus = (m_k > 0) && !m_local;
            chk("R8 ready", 16'(ready), 16'(m_k == 0));
            chk("R8 done", 16'(done), 16'(m_k > 0 && m_k == m_total));
            chk("R2 ale", 16'(ale), 16'(bus && ph == 0));
            chk("R3 psen_n", 16'(psen_n), 16'(!(bus && ph == 2 && m_kind == 0)));
            chk("R4 rd_n", 16'(rd_n), 16'(!(bus && ph == 2 && m_kind == 1)));
            chk("R5 wr_n", 16'(wr_n), 16'(!(bus && ph == 2 && m_kind >= 2)));
            chk("R4 ad_oe", 16'(ad_oe), 16'(bus && (ph == 0 || (m_kind >= 2 && (ph == 1 || ph == 2)))));
            if (bus && ph == 0) chk("R2 ad_out", 16'(ad_out), 16'(m_addr[7:0]));
            if (bus && m_kind >= 2 && (ph == 1 || ph == 2)) chk("R5 ad_out", 16'(ad_out), 16'(m_wdata));
            if (bus) chk("R2 hi_addr", 16'(hi_addr), 16'(m_addr[15:8]));
            if (m_k > 0 && m_k == m_total && m_kind < 2) chk(m_local ? "R9 rdata" : "R6 rdata", 16'(rdata), 16'(m_rd));
            // R7: one strobe at most, latch strobe low under any strobe
            chk("R7 exclusive", 16'(($countones({~psen_n, ~rd_n, ~wr_n}) <= 1) && !(ale && !(psen_n && rd_n && wr_n))), 16'd1);
        end
    end

    task automatic access(input logic [1:0] kind, input logic [15:0] addr,
                          input logic [7:0] wd, input logic ea_n, input bit poke_busy);
        @(negedge clk);
        while (m_k != 0) @(negedge clk);
        req_kind = kind; req_addr = addr; req_wdata = wd; ext_only_n = ea_n;
        req_valid = 1'b1;
        @(negedge clk);
        if (poke_busy) begin
            req_addr = addr ^ 16'h0F0F; req_kind = 2'b10; req_wdata = 8'h3C;
            repeat (3) @(negedge clk);
        end
        req_valid = 1'b0;
        while (m_k != 0) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: idle outputs during and after reset
        chk("R1 ready", 16'(ready), 16'd1);
        chk("R1 strobes", 16'({ale, psen_n, rd_n, wr_n, ad_oe, done}), 16'b011100);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 16'({ready, ale, psen_n, rd_n, wr_n, ad_oe, done}), 16'b1011100);
        run_chk = 1'b1;
        // writes with several patterns and address extremes (R5, R2)
        access(2'b10, 16'h1234, 8'hA5, 1'b0, 1'b0);
        access(2'b10, 16'h0000, 8'hFF, 1'b0, 1'b0);
        access(2'b11, 16'hFFFF, 8'h00, 1'b0, 1'b0);
        access(2'b10, 16'h8001, 8'h5C, 1'b0, 1'b0);
        // reads back (R4, R6), including a never-written location
        access(2'b01, 16'h1234, 8'h00, 1'b0, 1'b0);
        access(2'b01, 16'h0000, 8'h00, 1'b0, 1'b0);
        access(2'b01, 16'hFFFF, 8'h00, 1'b0, 1'b0);
        access(2'b01, 16'h8001, 8'h00, 1'b0, 1'b0);
        access(2'b01, 16'h4321, 8'h00, 1'b0, 1'b0);
        // fetches: forced external, on-chip, above limit (R3, R9)
        access(2'b00, 16'h0042, 8'h00, 1'b0, 1'b0);
        access(2'b00, 16'h0042, 8'h00, 1'b1, 1'b0);
        access(2'b00, 16'h0FFF, 8'h00, 1'b1, 1'b0);
        access(2'b00, 16'h1000, 8'h00, 1'b1, 1'b0);
        access(2'b00, 16'hC3E7, 8'h00, 1'b0, 1'b0);
        // requests while busy are ignored (R8)
        access(2'b01, 16'h1234, 8'h00, 1'b0, 1'b1);
        access(2'b10, 16'h2222, 8'h77, 1'b0, 1'b1);
        access(2'b01, 16'h2D2D, 8'h00, 1'b0, 1'b0);
        access(2'b01, 16'h2222, 8'h00, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule